// File: doc/BRIEF.md
# Parameter Frame Burst Transmitter

This block sends a burst of fixed-size parameter frames over a one-wire serial line ahead of each machine cycle, so that receivers hold the settings for the coming cycle before it begins. Every frame slot has a 24-bit payload and an enable bit, both written through a single-cycle write port. A pulse on `cycle_start` launches a burst. The sequencer visits the slots in rising index order and skips those that are disabled. For each enabled slot it builds a 40-bit word from the slot index, the payload and a CRC byte that it computes itself. The word then leaves the block at the line bit rate.

When the last slot has been visited, `data_valid` pulses for one clock to mark the whole set as complete. A cycle-start pulse that arrives while a burst is still in progress does not restart the burst and sets a sticky `overrun` flag.

The sequencer has four states. In SQ_IDLE it waits for an accepted start. SQ_PICK examines one slot: it goes to SQ_WAIT if the slot is enabled, moves to the next slot if it is not, and goes to SQ_FIN after the last slot. SQ_WAIT waits for the serializer to finish the current frame, then goes back to SQ_PICK, or to SQ_FIN after the last slot. SQ_FIN raises `data_valid` and returns to SQ_IDLE.

The serializer has five states. It goes from SR_IDLE to SR_START on a load, then SR_START to SR_DATA, SR_DATA to SR_STOP after 40 bits, SR_STOP to SR_GAP, and SR_GAP back to SR_IDLE after the idle bits. Each bit lasts `BIT_DIV` clocks; 10 gives 10 Mbit/s from a 100 MHz clock.

Top module: `frame_burst_tx`

## Requirements
- R1: After reset `ser_out` is 1, and `busy`, `data_valid` and `overrun` are 0. The line stays at 1 whenever `busy` is 0.
- R2: A frame on the line is one start bit of 0, then 40 bits most significant bit first, then one stop bit of 1. Every bit lasts `BIT_DIV` clocks. Word bits [39:32] hold the slot index, bits [31:8] hold the slot payload and bits [7:0] hold the CRC.
- R3: The CRC is CRC-8 with generator 0x07 (x^8+x^2+x+1) and a zero initial value. It is computed over word bits [39:8], taken from the most significant bit down.
- R4: A burst sends exactly the slots whose enable bit is 1, and sends them in ascending index order.
- R5: After each stop bit the line stays at 1 for at least two further bit times before the next start bit.
- R6: `data_valid` is high for exactly one clock after the last enabled frame of a burst has finished, including its idle bits. If no slot is enabled, the pulse still occurs and no frame is sent.
- R7: A `cycle_start` pulse while `busy` is 1 neither restarts nor lengthens the burst, and it sets `overrun`. `overrun` stays at 1 until the next accepted `cycle_start` clears it.
- R8: A write with `wr_en` at 1 stores `wr_data` and `wr_enable` into slot `wr_addr`. A slot's payload is captured when its frame is loaded, so a write to a slot that has already been sent appears only in the next burst.
- R9: `busy` is 1 from the clock after an accepted `cycle_start` up to and including the clock in which `data_valid` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Slot write strobe |
| wr_addr | input | IW | Slot index to write |
| wr_data | input | 24 | Payload to store |
| wr_enable | input | 1 | Enable bit to store with the payload |
| cycle_start | input | 1 | Burst launch pulse |
| ser_out | output | 1 | Serial line, idle high |
| busy | output | 1 | Burst in progress |
| data_valid | output | 1 | One-clock pulse when the burst is complete |
| overrun | output | 1 | Sticky flag for a start pulse received while busy |

## Verification
The bench runs a configuration with 8 slots and 4 clocks per bit, and decodes the line with its own mid-bit receiver. It applies a sweep of enable masks: all slots, the even slots, the odd slots, none, only the two end slots, and a block in the middle. This shows whether the block skips slots correctly, keeps the ascending order, and handles the empty burst. Payloads follow an arithmetic pattern that changes every burst, so a CRC or bit-order error cannot hide behind a constant word. A start pulse in the middle of a burst and a rewrite of a slot that has already been sent separate correct overrun handling and correct payload capture at load time from a restart or from reading the slot late.

// File: rtl/frame_pkg.sv
package frame_pkg;
    localparam int FRAME_W  = 40;
    localparam int DATA_W   = 24;
    localparam int CRC_W    = 8;
    localparam int NUM_W    = 8;
    localparam int MSG_W    = FRAME_W - CRC_W;
    localparam int GAP_BITS = 2;
    localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;

    typedef enum logic [1:0] {
        SQ_IDLE,
        SQ_PICK,
        SQ_WAIT,
        SQ_FIN
    } seq_state_t;

    typedef enum logic [2:0] {
        SR_IDLE,
        SR_START,
        SR_DATA,
        SR_STOP,
        SR_GAP
    } ser_state_t;
endpackage

// File: rtl/frame_bank.sv
module frame_bank
    import frame_pkg::*;
#(
    parameter int NUM_FRAMES = 128,
    localparam int IW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_enable,
    input  logic [IW-1:0]     rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_enable
);
    logic [DATA_W-1:0]     payload [NUM_FRAMES];
    logic [NUM_FRAMES-1:0] enable_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            enable_q <= '0;
        end else if (wr_en && (int'(wr_idx) < NUM_FRAMES)) begin
            enable_q[wr_idx] <= wr_enable;
        end
    end

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_idx) < NUM_FRAMES)) begin
            payload[wr_idx] <= wr_data;
        end
    end

    always_comb begin
        rd_data   = payload[rd_idx];
        rd_enable = enable_q[rd_idx];
    end
endmodule

// File: rtl/frame_crc8.sv
module frame_crc8
    import frame_pkg::*;
(
    input  logic [MSG_W-1:0] msg,
    output logic [CRC_W-1:0] crc
);
    logic [CRC_W-1:0] stage [MSG_W+1];

    assign stage[0] = '0;

    for (genvar i = 0; i < MSG_W; i++) begin : g_step
        logic fb;
        assign fb = stage[i][CRC_W-1] ^ msg[MSG_W-1-i];
        assign stage[i+1] = {stage[i][CRC_W-2:0], 1'b0} ^ ({CRC_W{fb}} & CRC_POLY);
    end

    assign crc = stage[MSG_W];
endmodule

// File: rtl/frame_serializer.sv
module frame_serializer
    import frame_pkg::*;
#(
    parameter int BIT_DIV = 10,
    localparam int CW = (BIT_DIV > 1) ? $clog2(BIT_DIV) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [FRAME_W-1:0] frame,
    output logic               line,
    output logic               done
);
    ser_state_t         state_q, state_d;
    logic [CW-1:0]      tick_q;
    logic [5:0]         bit_q;
    logic [FRAME_W-1:0] shreg_q;
    logic               tick_last;

    assign tick_last = (tick_q == CW'(BIT_DIV - 1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE:  if (load) state_d = SR_START;
            SR_START: if (tick_last) state_d = SR_DATA;
            SR_DATA:  if (tick_last && bit_q == 6'(FRAME_W - 1)) state_d = SR_STOP;
            SR_STOP:  if (tick_last) state_d = SR_GAP;
            SR_GAP:   if (tick_last && bit_q == 6'(GAP_BITS - 1)) state_d = SR_IDLE;
            default:  state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SR_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q  <= '0;
            bit_q   <= '0;
            shreg_q <= '0;
        end else if (state_q == SR_IDLE) begin
            tick_q <= '0;
            bit_q  <= '0;
            if (load) shreg_q <= frame;
        end else begin
            tick_q <= tick_last ? '0 : tick_q + 1'b1;
            if (tick_last) begin
                bit_q <= (state_d != state_q) ? '0 : bit_q + 1'b1;
                if (state_q == SR_DATA) shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
            end
        end
    end

    always_comb begin
        unique case (state_q)
            SR_START: line = 1'b0;
            SR_DATA:  line = shreg_q[FRAME_W-1];
            default:  line = 1'b1;
        endcase
        done = (state_q == SR_GAP) && tick_last && (bit_q == 6'(GAP_BITS - 1));
    end

    assert_load_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        load |-> state_q == SR_IDLE);
    assert_gap_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == SR_STOP || state_q == SR_GAP) |=> line);
endmodule

// File: rtl/frame_burst_tx.sv
module frame_burst_tx
    import frame_pkg::*;
#(
    parameter int NUM_FRAMES = 128,
    parameter int BIT_DIV    = 10,
    localparam int IW = (NUM_FRAMES > 1) ? $clog2(NUM_FRAMES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              wr_enable,
    input  logic              cycle_start,
    output logic              ser_out,
    output logic              busy,
    output logic              data_valid,
    output logic              overrun
);
    localparam logic [IW-1:0] LAST_IDX = IW'(NUM_FRAMES - 1);

    seq_state_t         state_q, state_d;
    logic [IW-1:0]      idx_q;
    logic               overrun_q;
    logic [DATA_W-1:0]  slot_data;
    logic               slot_en;
    logic [NUM_W-1:0]   frame_num;
    logic [CRC_W-1:0]   crc;
    logic               load;
    logic               ser_done;
    logic               at_last;

    frame_bank #(.NUM_FRAMES(NUM_FRAMES)) u_bank (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_addr),
        .wr_data   (wr_data),
        .wr_enable (wr_enable),
        .rd_idx    (idx_q),
        .rd_data   (slot_data),
        .rd_enable (slot_en)
    );

    always_comb begin
        frame_num = '0;
        frame_num[IW-1:0] = idx_q;
    end

    frame_crc8 u_crc (
        .msg (MSG_W'({frame_num, slot_data})),
        .crc (crc)
    );

    frame_serializer #(.BIT_DIV(BIT_DIV)) u_ser (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .frame ({frame_num, slot_data, crc}),
        .line  (ser_out),
        .done  (ser_done)
    );

    assign at_last = (idx_q == LAST_IDX);

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SQ_IDLE: if (cycle_start) state_d = SQ_PICK;
            SQ_PICK: begin
                if (slot_en)      state_d = SQ_WAIT;
                else if (at_last) state_d = SQ_FIN;
            end
            SQ_WAIT: if (ser_done) state_d = at_last ? SQ_FIN : SQ_PICK;
            SQ_FIN:  state_d = SQ_IDLE;
            default: state_d = SQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= SQ_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q     <= '0;
            overrun_q <= 1'b0;
        end else begin
            if (state_q == SQ_IDLE && cycle_start) idx_q <= '0;
            else if (state_q == SQ_PICK && !slot_en && !at_last) idx_q <= idx_q + 1'b1;
            else if (state_q == SQ_WAIT && ser_done && !at_last) idx_q <= idx_q + 1'b1;

            if (cycle_start) overrun_q <= (state_q != SQ_IDLE);
        end
    end

    always_comb begin
        load       = (state_q == SQ_PICK) && slot_en;
        busy       = (state_q != SQ_IDLE);
        data_valid = (state_q == SQ_FIN);
        overrun    = overrun_q;
    end

    assert_line_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ser_out);
    assert_dv_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        data_valid |=> !data_valid);
    assert_overrun_set_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && busy) |=> overrun);
    assert_no_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && busy && !data_valid) |=> busy);
    assert_busy_after_start_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cycle_start && !busy) |=> busy);
endmodule

// File: tb/sim_frame_burst_tx.sv
`timescale 1ns/1ps
module sim_frame_burst_tx;
    localparam int NF  = 8;
    localparam int DIV = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_addr = '0;
    logic [23:0] wr_data = '0;
    logic        wr_enable = 1'b0;
    logic        cycle_start = 1'b0;
    logic        ser_out, busy, data_valid, overrun;

    int checks = 0;
    int fails  = 0;

    logic [23:0] exp_data [NF];
    logic        exp_en   [NF];
    logic [23:0] snap_data [NF];
    logic        snap_en   [NF];
    logic [39:0] rx_word [32];
    int          rx_n = 0;
    int          hi_run = 0;

    always #2.5 clk = ~clk;

    frame_burst_tx #(.NUM_FRAMES(NF), .BIT_DIV(DIV)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .wr_enable(wr_enable), .cycle_start(cycle_start),
        .ser_out(ser_out), .busy(busy), .data_valid(data_valid), .overrun(overrun)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint expv);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=0x%0h expected=0x%0h", req, what, act, expv);
        end
    endtask

    function automatic logic [7:0] ref_crc(input logic [31:0] m);
        logic [7:0] r = 8'h00;
        for (int i = 31; i >= 0; i--) begin
            logic top = r[7] ^ m[i];
            r = r << 1;
            if (top) r = r ^ 8'h07;
        end
        return r;
    endfunction

    // Line receiver, samples mid-bit at the falling clock edge
    initial begin
        logic prev = 1'b1;
        forever begin
            @(negedge clk);
            if (rst_n && prev && !ser_out) begin
                logic [39:0] w = '0;
                chk(hi_run >= 3 * DIV, "R5", "idle high clocks before start", hi_run, 3 * DIV);
                hi_run = 0;
                repeat (DIV / 2) @(negedge clk);
                chk(ser_out == 1'b0, "R2", "start bit", ser_out, 0);
                for (int b = 0; b < 40; b++) begin
                    repeat (DIV) @(negedge clk);
                    w = {w[38:0], ser_out};
                end
                repeat (DIV) @(negedge clk);
                chk(ser_out == 1'b1, "R2", "stop bit", ser_out, 1);
                if (rx_n < 32) rx_word[rx_n] = w;
                rx_n++;
                prev = 1'b1;
                hi_run = DIV / 2 + 1;
            end else begin
                prev = ser_out;
                if (ser_out) hi_run++;
            end
        end
    end

    task automatic write_slot(input int i, input logic [23:0] d, input logic e);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 3'(i); wr_data = d; wr_enable = e;
        exp_data[i] = d; exp_en[i] = e;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic fire();
        for (int i = 0; i < NF; i++) begin
            snap_data[i] = exp_data[i];
            snap_en[i] = exp_en[i];
        end
        rx_n = 0;
        @(negedge clk);
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        chk(busy == 1'b1, "R9", "busy after start", busy, 1);
    endtask

    task automatic finish_burst(input string tag);
        int guard = 0;
        int n = 0;
        while (!data_valid && guard < 20000) begin
            @(negedge clk);
            guard++;
        end
        chk(data_valid == 1'b1, "R6", {tag, " data_valid seen"}, data_valid, 1);
        chk(busy == 1'b1, "R9", {tag, " busy during data_valid"}, busy, 1);
        @(negedge clk);
        chk(data_valid == 1'b0, "R6", {tag, " data_valid one clock"}, data_valid, 0);
        chk(busy == 1'b0, "R9", {tag, " busy cleared"}, busy, 0);
        for (int i = 0; i < NF; i++) begin
            if (snap_en[i]) begin
                if (n < rx_n && n < 32) begin
                    logic [31:0] m = {8'(i), snap_data[i]};
                    chk(rx_word[n][39:32] == 8'(i), "R4", {tag, " frame number order"},
                        rx_word[n][39:32], i);
                    chk(rx_word[n][31:8] == snap_data[i], "R2", {tag, " payload"},
                        rx_word[n][31:8], snap_data[i]);
                    chk(rx_word[n][7:0] == ref_crc(m), "R3", {tag, " crc"},
                        rx_word[n][7:0], ref_crc(m));
                end
                n++;
            end
        end
        chk(rx_n == n, "R4", {tag, " frame count"}, rx_n, n);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [7:0] masks [6];
        masks[0] = 8'hFF; masks[1] = 8'h55; masks[2] = 8'hAA;
        masks[3] = 8'h00; masks[4] = 8'h81; masks[5] = 8'h3C;
        for (int i = 0; i < NF; i++) begin exp_data[i] = '0; exp_en[i] = 1'b0; end

        repeat (3) @(negedge clk);
        chk(ser_out == 1'b1, "R1", "reset line", ser_out, 1);
        chk(busy == 1'b0, "R1", "reset busy", busy, 0);
        chk(data_valid == 1'b0, "R1", "reset data_valid", data_valid, 0);
        chk(overrun == 1'b0, "R1", "reset overrun", overrun, 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // sweep of enable masks and arithmetic payloads (R2 R3 R4 R5 R6 R8)
        for (int b = 0; b < 6; b++) begin
            for (int i = 0; i < NF; i++)
                write_slot(i, 24'(b * 24'h13579B + i * 24'h2468A + 24'hA50000 * (i & 1)),
                           masks[b][i]);
            fire();
            finish_burst($sformatf("sweep%0d", b));
            chk(overrun == 1'b0, "R7", "no overrun on clean burst", overrun, 0);
        end

        // overrun: start pulse mid-burst is ignored (R7)
        for (int i = 0; i < NF; i++) write_slot(i, 24'hC0FFEE ^ 24'(i * 24'h111111), 1'b1);
        fire();
        repeat (300) @(negedge clk);
        cycle_start = 1'b1;
        @(negedge clk);
        cycle_start = 1'b0;
        chk(overrun == 1'b1, "R7", "overrun set", overrun, 1);
        finish_burst("overrun");
        chk(overrun == 1'b1, "R7", "overrun held after burst", overrun, 1);
        fire();
        chk(overrun == 1'b0, "R7", "overrun cleared by accepted start", overrun, 0);

        // rewrite of an already sent slot lands in the next burst only (R8)
        while (rx_n < 1) @(negedge clk);
        write_slot(0, 24'h0BADF0, 1'b1);
        finish_burst("latch_old");
        fire();
        finish_burst("latch_new");
        chk(rx_word[0][31:8] == 24'h0BADF0, "R8", "rewritten slot in next burst",
            rx_word[0][31:8], 24'h0BADF0);
        chk(ser_out == 1'b1, "R1", "line idle after bursts", ser_out, 1);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule